// File: doc/BRIEF.md
# Segmented Masked-Write Single-Port Memory

This block is a single-port memory with a wide data word and a per-segment write mask. It is built from several narrow single-port banks that have no write mask. Each bank holds one segment of the word, and every bank has the full depth of the wide memory. Clock, address and enable go unchanged to every bank. Each bank receives only its own slice of the write data and drives the same slice of the read word.

The wide write mask is applied by gating each bank's write mode with that bank's mask bit, so a bank whose mask bit is clear does not write. A bank in that state sees a plain read cycle instead. During a partial write, the segments that are not written therefore return the addressed word's stored data one cycle later. This behaviour is accepted.

Each bank latches its read address on a read cycle and presents the array contents at that latched address. Read data therefore appears one cycle after the request. The arrays have no reset, so they can map onto block RAM. Only the read address registers are reset.

Top module: `masked_split_mem`

## Requirements
- R1: With `en`=1, `wr`=1 and every `wmask` bit set, the whole `wdata` word is stored at `addr`. A later read of that address returns it.
- R2: In a write, segment i is bits [(i+1)*SEG_W-1 : i*SEG_W] of `wdata` and `rdata`, and it is controlled by `wmask[i]`. Only segments whose mask bit is 1 are updated. All other segments of that word keep their earlier contents.
- R3: A write with `wmask` all zero leaves the memory unchanged.
- R4: With `en`=0, nothing is written whatever `wr`, `wmask` and `wdata` are. No bank's read address changes, so `rdata` holds its value.
- R5: A read is `en`=1 with `wr`=0. In the cycle after the read clock edge, `rdata` shows the word at the requested address. It holds that value until a later read or write changes what is addressed.
- R6: During a write, each segment whose mask bit is 0 performs a read of `addr`. In the following cycle that segment of `rdata` shows the stored data of `addr`. Each segment whose mask bit is 1 keeps its earlier read address.
- R7: A synchronous active-high `rst` sets every bank's read address to 0, so after reset `rdata` shows word 0. The memory contents are not cleared.
- R8: The lowest address (0) and the highest address (DEPTH-1) are written and read like any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all banks |
| rst | input | 1 | Synchronous active-high reset of the read address registers |
| en | input | 1 | Access enable |
| wr | input | 1 | Write mode (1 = write, 0 = read) |
| addr | input | ADDR_W | Word address |
| wmask | input | SEGS | Write enable per segment |
| wdata | input | SEGS*SEG_W | Write word |
| rdata | output | SEGS*SEG_W | Read word, one cycle after the request |

## Verification
Full-word writes followed by reads of the same addresses show that each bank stores and returns its own slice. Alternating and single-bit mask patterns written over a known word separate the segments that are updated from the segments that are kept. A write with a zero mask and a write attempted with `en` low must both leave the memory unchanged. A partial write issued after a read of a different address separates the segments that now read the new address from the segments that keep their old read address. Accesses at address 0 and at the top address, together with a reset issued while a non-zero address is latched, cover the edges of the address range and the reset value of the read addresses.

// File: rtl/msm_pkg.sv
package msm_pkg;
  // Address width for a given depth, at least one bit.
  function automatic int unsigned addr_bits(input int unsigned depth);
    int unsigned b;
    b = $clog2(depth);
    return (b < 1) ? 1 : b;
  endfunction
endpackage

// File: rtl/msm_wgate.sv
module msm_wgate #(
  parameter int SEGS = 4
) (
  input  logic            en,
  input  logic            wr,
  input  logic [SEGS-1:0] wmask,
  output logic [SEGS-1:0] seg_wmode,
  output logic [SEGS-1:0] seg_we,
  output logic [SEGS-1:0] seg_re
);
  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    always_comb begin
      seg_wmode[g] = wr & wmask[g];
      seg_we[g]    = en & seg_wmode[g];
      seg_re[g]    = en & ~seg_wmode[g];
    end
  end
endmodule

// File: rtl/msm_bank.sv
module msm_bank #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int AW   = msm_pkg::addr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wmode,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0]  ram [DEPTH];
  logic [AW-1:0] addr_q;

  // Array write without reset, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (en && wmode) ram[addr] <= wdata;
  end

  // Read address is captured on a read cycle.
  always_ff @(posedge clk) begin
    if (rst)               addr_q <= '0;
    else if (en && !wmode) addr_q <= addr;
  end

  assign rdata = ram[addr_q];
endmodule

// File: rtl/masked_split_mem.sv
module masked_split_mem #(
  parameter int SEG_W   = 8,
  parameter int SEGS    = 4,
  parameter int DEPTH   = 64,
  localparam int ADDR_W = msm_pkg::addr_bits(DEPTH),
  localparam int WIDE_W = SEG_W * SEGS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEGS-1:0]   wmask,
  input  logic [WIDE_W-1:0] wdata,
  output logic [WIDE_W-1:0] rdata
);
  logic [SEGS-1:0] seg_wmode;
  logic [SEGS-1:0] seg_we;
  logic [SEGS-1:0] seg_re;

  msm_wgate #(.SEGS(SEGS)) u_gate (
    .en        (en),
    .wr        (wr),
    .wmask     (wmask),
    .seg_wmode (seg_wmode),
    .seg_we    (seg_we),
    .seg_re    (seg_re)
  );

  for (genvar g = 0; g < SEGS; g++) begin : g_bank
    msm_bank #(.W(SEG_W), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .wmode (seg_wmode[g]),
      .addr  (addr),
      .wdata (wdata[g*SEG_W +: SEG_W]),
      .rdata (rdata[g*SEG_W +: SEG_W])
    );
  end
endmodule

// File: rtl/msm_check.sv
module msm_check #(
  parameter int SEGS   = 4,
  parameter int WIDE_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              wr,
  input logic [SEGS-1:0]   wmask,
  input logic [WIDE_W-1:0] rdata,
  input logic [SEGS-1:0]   seg_we,
  input logic [SEGS-1:0]   seg_re
);
  // R2: no bank writes outside the mask
  a_r2_we_within_mask: assert property (@(posedge clk) disable iff (rst)
    (seg_we & ~wmask) == '0);

  // R1: full mask writes every bank
  a_r1_full_write: assert property (@(posedge clk) disable iff (rst)
    (en && wr && (&wmask)) |-> (&seg_we));

  // R4: no bank activity while disabled
  a_r4_no_access_idle: assert property (@(posedge clk) disable iff (rst)
    !en |-> (seg_we == '0 && seg_re == '0));

  // R4: read word holds across a disabled cycle
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(rdata));

  // R6: masked-off banks read during a write
  a_r6_clear_bank_reads: assert property (@(posedge clk) disable iff (rst)
    (en && wr) |-> (seg_re == ~wmask));

  // R3: zero mask writes nothing
  a_r3_zero_mask: assert property (@(posedge clk) disable iff (rst)
    (wmask == '0) |-> (seg_we == '0));
endmodule

bind masked_split_mem msm_check #(.SEGS(SEGS), .WIDE_W(WIDE_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .wr     (wr),
  .wmask  (wmask),
  .rdata  (rdata),
  .seg_we (seg_we),
  .seg_re (seg_re)
);

// File: tb/masked_split_mem_test.sv
module masked_split_mem_test;
  localparam int SEG_W = 8;
  localparam int SEGS  = 4;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int WW    = SEG_W * SEGS;

  logic          clk = 0;
  logic          rst = 1;
  logic          en = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [SEGS-1:0] wmask = '0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;

  always #5 clk = ~clk;

  masked_split_mem #(.SEG_W(SEG_W), .SEGS(SEGS), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .en(en), .wr(wr), .addr(addr),
    .wmask(wmask), .wdata(wdata), .rdata(rdata)
  );

  typedef struct { logic [WW-1:0] exp; string tag; } item_t;
  item_t sb[$];

  logic [SEG_W-1:0] model [DEPTH][SEGS];
  int aq [SEGS];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  function automatic logic [WW-1:0] expected();
    logic [WW-1:0] e;
    for (int i = 0; i < SEGS; i++) e[i*SEG_W +: SEG_W] = model[aq[i]][i];
    return e;
  endfunction

  function automatic logic [WW-1:0] pat(input int a);
    return 32'hA55A_0F0F ^ (a * 32'h0103_0507);
  endfunction

  task automatic op(input logic e, input logic w, input int a,
                    input logic [SEGS-1:0] m, input logic [WW-1:0] d,
                    input string tag);
    @(negedge clk);
    en = e; wr = w; addr = AW'(a); wmask = m; wdata = d;
    @(posedge clk);
    #1;
    for (int i = 0; i < SEGS; i++) begin
      if (e && w && m[i]) model[a][i] = d[i*SEG_W +: SEG_W];
      if (e && !(w && m[i])) aq[i] = a;
    end
    sb.push_back('{expected(), tag});
  endtask

  task automatic do_reset(input bool_push);
    @(negedge clk);
    rst = 1; en = 0;
    @(posedge clk);
    #1;
    for (int i = 0; i < SEGS; i++) aq[i] = 0;
    if (bool_push) sb.push_back('{expected(), "R7"});
    @(negedge clk);
    rst = 0;
  endtask

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      vectors++;
      if (rdata !== it.exp) begin
        miscompares++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  initial begin
    for (int i = 0; i < SEGS; i++) aq[i] = 0;
    do_reset(0);
    // R8 / R1: full writes including both ends of the address range
    op(1, 1, 0, 4'hF, pat(0), "R8");
    op(1, 1, DEPTH-1, 4'hF, pat(DEPTH-1), "R8");
    for (int a = 1; a < 8; a++) op(1, 1, a, 4'hF, pat(a), "R1");
    // R1 / R5: read back, then idle hold
    for (int a = 0; a < 8; a++) op(1, 0, a, 4'h0, '0, "R1");
    op(0, 0, 3, 4'h0, '0, "R5");
    op(0, 0, 9, 4'h0, '0, "R5");
    op(1, 0, DEPTH-1, 4'h0, '0, "R8");
    op(1, 0, 0, 4'h0, '0, "R8");
    // R2: alternating and single-bit masks on address 3
    op(1, 1, 3, 4'b0101, 32'h1122_3344, "R2");
    op(1, 0, 3, 4'h0, '0, "R2");
    op(1, 1, 3, 4'b1010, 32'h5566_7788, "R2");
    op(1, 0, 3, 4'h0, '0, "R2");
    op(1, 1, 3, 4'b0001, 32'hDEAD_BEEF, "R2");
    op(1, 0, 3, 4'h0, '0, "R2");
    // R6: partial write to address 5 after a read of address 3
    op(1, 1, 5, 4'b0011, 32'hCAFE_F00D, "R6");
    op(1, 1, 6, 4'b1000, 32'h0BAD_C0DE, "R6");
    op(1, 0, 5, 4'h0, '0, "R6");
    // R3: zero mask write, then read
    op(1, 1, 2, 4'h0, 32'hFFFF_FFFF, "R3");
    op(1, 0, 2, 4'h0, '0, "R3");
    // R4: write attempted while disabled, then read
    op(0, 1, 1, 4'hF, 32'h1234_5678, "R4");
    op(1, 0, 1, 4'h0, '0, "R4");
    // R7: latch a non-zero address, reset, expect word 0
    op(1, 0, 6, 4'h0, '0, "R7");
    do_reset(1);
    op(0, 0, 0, 4'h0, '0, "R7");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule